// File: doc/BRIEF.md
# USB IN Endpoint Response Controller

This block decides how a single full-speed USB device IN endpoint answers each token that reaches it. It is given the kind of token, the current frame number, the byte count waiting in the transmit FIFO and the endpoint configuration. For every token it produces one registered response: a data packet with length and PID, a zero-length packet, a NAK handshake, an ACK handshake, or no response. Packet serialisation, CRC, line coding, the FIFO storage and the bus interface are handled by neighbouring blocks.

The endpoint holds four pieces of state. These are the NAK status, the active flag, the even/odd frame select for isochronous transfers, and the data PID for interrupt and bulk transfers. Software changes them through single-cycle strobes. A USB reset sets the NAK status. It also clears the active flag, except on endpoint 0. The data PID advances only when the host acknowledges a data packet from an interrupt, bulk or control endpoint. A NAK status has different results depending on endpoint type. A non-isochronous endpoint answers NAK. An isochronous endpoint sends a zero-length packet instead.

Top module: `usb_in_ep_responder`

## Requirements
- R1: After rst_n is released: nakSts is 1, dataPid is 0 (DATA0), the even/odd select is even, respValid is 0, and epActive is 1 only when EP_NUM is 0.
- R2: swNakSet sets nakSts and swNakClr clears it, with set taking priority when both are high. usbReset also sets nakSts. The new value applies from the next cycle, so a token in the same cycle as a NAK strobe is judged on the old value.
- R3: When nakSts is 1, an IN token on a non-isochronous endpoint (epType 0 control, 2 bulk, 3 interrupt) is answered with NAK, whatever the FIFO holds.
- R4: When nakSts is 0, an IN token on a non-isochronous endpoint is answered with NAK if fifoCount is 0. Otherwise it is answered with DATA of length min(fifoCount, maxPktSize) carrying the current dataPid.
- R5: Every response other than DATA reports respLen 0 and respPid 0.
- R6: On an isochronous endpoint (epType 1), an IN token is answered with DATA only when all three hold: nakSts is 0, frameNum bit 0 equals the even/odd select, and fifoCount is non-zero. The length is min(fifoCount, maxPktSize) and the PID is 0. In every other case the answer is a zero-length packet (ZLP) and never NAK. swSetOdd selects odd (1) and swSetEven selects even (0). Odd wins if both are high.
- R7: A SETUP token on an active endpoint is always answered with ACK, whatever nakSts is. A SETUP token takes priority over an IN token in the same cycle.
- R8: While epActive is 0, every token gets the response kind NONE. swActivate sets epActive. When EP_NUM is not 0, usbReset clears epActive and wins over swActivate.
- R9: dataPid toggles on hsAck only when the most recent response was DATA on a non-isochronous endpoint. It is unchanged after hsTimeout, after a stray hsAck, and after isochronous DATA. swSetData0 forces DATA0 and wins over a simultaneous toggle.
- R10: Each token gives one respValid pulse in the cycle after it. respValid is 0 when no token was presented. Response kinds are encoded as NONE=0, DATA=1, ZLP=2, NAK=3, ACK=4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| usbReset | input | 1 | USB bus reset detected (one-cycle strobe) |
| inTok | input | 1 | IN token for this endpoint |
| setupTok | input | 1 | SETUP data packet for this endpoint |
| frameNum | input | FRAME_W | Current frame number |
| fifoCount | input | CNT_W | Bytes waiting in the transmit FIFO |
| epType | input | 2 | 0 control, 1 isochronous, 2 bulk, 3 interrupt |
| maxPktSize | input | LEN_W | Maximum packet size in bytes |
| swActivate | input | 1 | Software strobe: mark the endpoint active |
| swNakSet | input | 1 | Software strobe: set NAK status |
| swNakClr | input | 1 | Software strobe: clear NAK status |
| swSetEven | input | 1 | Software strobe: select even frames |
| swSetOdd | input | 1 | Software strobe: select odd frames |
| swSetData0 | input | 1 | Software strobe: next PID is DATA0 |
| hsAck | input | 1 | Host ACK received for the last data packet |
| hsTimeout | input | 1 | Handshake timeout for the last data packet |
| respValid | output | 1 | Response decision valid |
| respKind | output | 3 | Response kind (R10 encoding) |
| respLen | output | LEN_W | Data packet length in bytes |
| respPid | output | 1 | Data packet PID (0 DATA0, 1 DATA1) |
| nakSts | output | 1 | NAK status |
| epActive | output | 1 | Endpoint active flag |
| dataPid | output | 1 | Current interrupt/bulk data PID |

## Verification
Two pairs of functions can fall on the same clock edge: a software NAK strobe with an IN token, and a host ACK with a forced DATA0. The bench raises both strobes in the same cycle. It expects the token to be judged on the NAK status from before the strobe, and the forced DATA0 to win over the toggle. A near-exhaustive sweep covers endpoint type, NAK status, parity select, frame parity, FIFO occupancy and packet size. Each response is compared with a value the bench computes arithmetically.

// File: rtl/usb_in_ep_pkg.sv
package usb_in_ep_pkg;

  typedef enum logic [2:0] {
    RESP_NONE = 3'd0,
    RESP_DATA = 3'd1,
    RESP_ZLP  = 3'd2,
    RESP_NAK  = 3'd3,
    RESP_ACK  = 3'd4
  } respKind_e;

  typedef enum logic [1:0] {
    EP_CTRL = 2'd0,
    EP_ISO  = 2'd1,
    EP_BULK = 2'd2,
    EP_INTR = 2'd3
  } epType_e;

  // Strobes from the control to the datapath
  typedef struct packed {
    logic      fire;       // a token is being answered this cycle
    respKind_e kind;       // chosen answer
    logic      isoPid;     // isochronous: data PID forced to DATA0
    logic      pidToggle;  // advance the data PID
    logic      pidClear;   // force DATA0
  } epStrobe_t;

endpackage

// File: rtl/usb_in_ep_ctrl.sv
module usb_in_ep_ctrl
  import usb_in_ep_pkg::*;
#(
  parameter int EP_NUM = 1
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      usbReset,
  input  logic      inTok,
  input  logic      setupTok,
  input  logic      framePar,
  input  epType_e   epType,
  input  logic      swActivate,
  input  logic      swNakSet,
  input  logic      swNakClr,
  input  logic      swSetEven,
  input  logic      swSetOdd,
  input  logic      swSetData0,
  input  logic      hsAck,
  input  logic      hsTimeout,
  input  logic      fifoHasData,
  output epStrobe_t strb,
  output logic      nakSts,
  output logic      epActive
);

  logic      evenOdd;
  logic      pendingAck;
  logic      isIso;
  respKind_e kindNext;

  assign isIso = (epType == EP_ISO);

  // Response decision
  always_comb begin
    kindNext = RESP_NONE;
    if (!epActive) begin
      kindNext = RESP_NONE;
    end else if (setupTok) begin
      kindNext = RESP_ACK;
    end else if (inTok) begin
      if (isIso) begin
        if (!nakSts && (framePar == evenOdd) && fifoHasData) kindNext = RESP_DATA;
        else                                                 kindNext = RESP_ZLP;
      end else begin
        if (!nakSts && fifoHasData) kindNext = RESP_DATA;
        else                        kindNext = RESP_NAK;
      end
    end
  end

  always_comb begin
    strb.fire      = inTok | setupTok;
    strb.kind      = kindNext;
    strb.isoPid    = isIso;
    strb.pidClear  = swSetData0;
    strb.pidToggle = hsAck & pendingAck & ~swSetData0;
  end

  // NAK status
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    nakSts <= 1'b1;
    else if (usbReset || swNakSet) nakSts <= 1'b1;
    else if (swNakClr)             nakSts <= 1'b0;
  end

  // Frame parity select
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         evenOdd <= 1'b0;
    else if (swSetOdd)  evenOdd <= 1'b1;
    else if (swSetEven) evenOdd <= 1'b0;
  end

  // Waiting for a host handshake on a non-isochronous data packet
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     pendingAck <= 1'b0;
    else if (usbReset)              pendingAck <= 1'b0;
    else if (strb.fire)             pendingAck <= (kindNext == RESP_DATA) && !isIso;
    else if (hsAck || hsTimeout)    pendingAck <= 1'b0;
  end

  // Active flag: endpoint 0 is always active, others follow software and bus reset
  generate
    if (EP_NUM == 0) begin : g_ep0
      logic unusedActivate;
      assign unusedActivate = swActivate;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) epActive <= 1'b1;
        else        epActive <= 1'b1;
      end
    end else begin : g_epn
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          epActive <= 1'b0;
        else if (usbReset)   epActive <= 1'b0;
        else if (swActivate) epActive <= 1'b1;
      end

      p_bus_reset_deactivates_r8: assert property (@(posedge clk) disable iff (!rst_n)
        usbReset |=> !epActive)
        else $error("p_bus_reset_deactivates_r8");
    end
  endgenerate

  p_bus_reset_naks_r2: assert property (@(posedge clk) disable iff (!rst_n)
    usbReset |=> nakSts)
    else $error("p_bus_reset_naks_r2");

  p_set_beats_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (swNakSet && swNakClr) |=> nakSts)
    else $error("p_set_beats_clear_r2");

  p_clear_only_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (swNakClr && !swNakSet && !usbReset) |=> !nakSts)
    else $error("p_clear_only_r2");

endmodule

// File: rtl/usb_in_ep_datapath.sv
module usb_in_ep_datapath
  import usb_in_ep_pkg::*;
#(
  parameter int LEN_W = 11,
  parameter int CNT_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  epStrobe_t        strb,
  input  logic [CNT_W-1:0] fifoCount,
  input  logic [LEN_W-1:0] maxPktSize,
  output logic             fifoHasData,
  output logic             respValid,
  output respKind_e        respKind,
  output logic [LEN_W-1:0] respLen,
  output logic             respPid,
  output logic             dataPid
);

  localparam int CMP_W = (LEN_W > CNT_W) ? LEN_W : CNT_W;

  logic [CMP_W-1:0] fifoExt;
  logic [CMP_W-1:0] mpsExt;
  logic [LEN_W-1:0] takeLen;
  logic             isData;

  assign fifoHasData = |fifoCount;
  assign fifoExt     = CMP_W'(fifoCount);
  assign mpsExt      = CMP_W'(maxPktSize);
  assign takeLen     = (fifoExt < mpsExt) ? LEN_W'(fifoExt) : maxPktSize;
  assign isData      = strb.fire && (strb.kind == RESP_DATA);

  // Registered response
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      respValid <= 1'b0;
      respKind  <= RESP_NONE;
      respLen   <= '0;
      respPid   <= 1'b0;
    end else begin
      respValid <= strb.fire;
      respKind  <= strb.fire ? strb.kind : RESP_NONE;
      respLen   <= isData ? takeLen : '0;
      respPid   <= (isData && !strb.isoPid) ? dataPid : 1'b0;
    end
  end

  // Data PID sequence
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              dataPid <= 1'b0;
    else if (strb.pidClear)  dataPid <= 1'b0;
    else if (strb.pidToggle) dataPid <= ~dataPid;
  end

  p_len_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    respValid |-> (respLen <= $past(maxPktSize)))
    else $error("p_len_bound_r4");

  p_nondata_empty_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (respKind != RESP_DATA) |-> (respLen == '0 && !respPid))
    else $error("p_nondata_empty_r5");

  p_pid_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!strb.pidToggle && !strb.pidClear) |=> $stable(dataPid))
    else $error("p_pid_hold_r9");

endmodule

// File: rtl/usb_in_ep_responder.sv
module usb_in_ep_responder
  import usb_in_ep_pkg::*;
#(
  parameter int EP_NUM  = 1,
  parameter int LEN_W   = 11,
  parameter int CNT_W   = 11,
  parameter int FRAME_W = 11
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               usbReset,
  input  logic               inTok,
  input  logic               setupTok,
  input  logic [FRAME_W-1:0] frameNum,
  input  logic [CNT_W-1:0]   fifoCount,
  input  logic [1:0]         epType,
  input  logic [LEN_W-1:0]   maxPktSize,
  input  logic               swActivate,
  input  logic               swNakSet,
  input  logic               swNakClr,
  input  logic               swSetEven,
  input  logic               swSetOdd,
  input  logic               swSetData0,
  input  logic               hsAck,
  input  logic               hsTimeout,
  output logic               respValid,
  output logic [2:0]         respKind,
  output logic [LEN_W-1:0]   respLen,
  output logic               respPid,
  output logic               nakSts,
  output logic               epActive,
  output logic               dataPid
);

  epStrobe_t strb;
  logic      fifoHasData;
  respKind_e kindReg;
  logic      unusedFrameHigh;

  assign unusedFrameHigh = ^frameNum;

  usb_in_ep_ctrl #(.EP_NUM(EP_NUM)) i_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .usbReset   (usbReset),
    .inTok      (inTok),
    .setupTok   (setupTok),
    .framePar   (frameNum[0]),
    .epType     (epType_e'(epType)),
    .swActivate (swActivate),
    .swNakSet   (swNakSet),
    .swNakClr   (swNakClr),
    .swSetEven  (swSetEven),
    .swSetOdd   (swSetOdd),
    .swSetData0 (swSetData0),
    .hsAck      (hsAck),
    .hsTimeout  (hsTimeout),
    .fifoHasData(fifoHasData),
    .strb       (strb),
    .nakSts     (nakSts),
    .epActive   (epActive)
  );

  usb_in_ep_datapath #(.LEN_W(LEN_W), .CNT_W(CNT_W)) i_datapath (
    .clk        (clk),
    .rst_n      (rst_n),
    .strb       (strb),
    .fifoCount  (fifoCount),
    .maxPktSize (maxPktSize),
    .fifoHasData(fifoHasData),
    .respValid  (respValid),
    .respKind   (kindReg),
    .respLen    (respLen),
    .respPid    (respPid),
    .dataPid    (dataPid)
  );

  assign respKind = kindReg;

  p_setup_ack_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (setupTok && epActive) |=> (respValid && respKind == RESP_ACK))
    else $error("p_setup_ack_r7");

  p_nak_blocks_data_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (inTok && !setupTok && epActive && nakSts && epType != EP_ISO) |=> (respKind == RESP_NAK))
    else $error("p_nak_blocks_data_r3");

  p_iso_never_nak_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (respValid && respKind == RESP_NAK) |-> ($past(epType) != EP_ISO))
    else $error("p_iso_never_nak_r6");

  p_inactive_silent_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!epActive && (inTok || setupTok)) |=> (respValid && respKind == RESP_NONE))
    else $error("p_inactive_silent_r8");

  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!inTok && !setupTok) |=> !respValid)
    else $error("p_idle_quiet_r10");

endmodule

// File: tb/test_usb_in_ep_responder.sv
module test_usb_in_ep_responder;

  localparam int LEN_W = 11;
  localparam int CNT_W = 11;
  localparam int FRAME_W = 11;
  localparam int K_NONE = 0, K_DATA = 1, K_ZLP = 2, K_NAK = 3, K_ACK = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic usbReset = 0, inTok = 0, setupTok = 0;
  logic [FRAME_W-1:0] frameNum = '0;
  logic [CNT_W-1:0]   fifoCount = '0;
  logic [1:0]         epType = 2'd2;
  logic [LEN_W-1:0]   maxPktSize = 11'd64;
  logic swActivate = 0, swNakSet = 0, swNakClr = 0, swSetEven = 0, swSetOdd = 0;
  logic swSetData0 = 0, hsAck = 0, hsTimeout = 0;
  logic respValid, respPid, nakSts, epActive, dataPid;
  logic [2:0] respKind;
  logic [LEN_W-1:0] respLen;

  int checks = 0;
  int fails = 0;
  int mPid = 0;

  always #2.5 clk = ~clk;

  usb_in_ep_responder #(.EP_NUM(1), .LEN_W(LEN_W), .CNT_W(CNT_W), .FRAME_W(FRAME_W)) i_usb_in_ep_responder (
    .clk(clk), .rst_n(rst_n), .usbReset(usbReset), .inTok(inTok), .setupTok(setupTok),
    .frameNum(frameNum), .fifoCount(fifoCount), .epType(epType), .maxPktSize(maxPktSize),
    .swActivate(swActivate), .swNakSet(swNakSet), .swNakClr(swNakClr),
    .swSetEven(swSetEven), .swSetOdd(swSetOdd), .swSetData0(swSetData0),
    .hsAck(hsAck), .hsTimeout(hsTimeout), .respValid(respValid), .respKind(respKind),
    .respLen(respLen), .respPid(respPid), .nakSts(nakSts), .epActive(epActive), .dataPid(dataPid)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic clearStrobes();
    usbReset = 0; inTok = 0; setupTok = 0; swActivate = 0; swNakSet = 0; swNakClr = 0;
    swSetEven = 0; swSetOdd = 0; swSetData0 = 0; hsAck = 0; hsTimeout = 0;
  endtask

  task automatic checkResp(input string req, input int k, input int len, input int pid);
    chk(req, "respValid", int'(respValid), 1);
    chk(req, "respKind", int'(respKind), k);
    chk(req, "respLen", int'(respLen), len);
    chk(req, "respPid", int'(respPid), pid);
  endtask

  initial begin
    #750000;
    checks++;
    fails++;
    $display("FAIL R10 watchdog: actual=timeout expected=finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #12;
    rst_n = 1'b1;
    #1;
    // R1 reset state
    chk("R1", "nakSts", int'(nakSts), 1);
    chk("R1", "epActive", int'(epActive), 0);
    chk("R1", "dataPid", int'(dataPid), 0);
    chk("R1", "respValid", int'(respValid), 0);
    step();

    // R8 inactive endpoint gives NONE
    fifoCount = 11'd4; inTok = 1; step(); clearStrobes();
    checkResp("R8", K_NONE, 0, 0);
    setupTok = 1; step(); clearStrobes();
    checkResp("R8", K_NONE, 0, 0);
    swActivate = 1; step(); clearStrobes();
    chk("R8", "epActive after activate", int'(epActive), 1);
    usbReset = 1; swActivate = 1; swNakClr = 1; step(); clearStrobes();
    chk("R8", "epActive after bus reset", int'(epActive), 0);
    chk("R2", "nakSts after bus reset", int'(nakSts), 1);
    swActivate = 1; step(); clearStrobes();

    // R10 idle cycle
    step();
    chk("R10", "respValid idle", int'(respValid), 0);

    // R7 setup acked with NAK set, and beats a simultaneous IN
    setupTok = 1; step(); clearStrobes();
    checkResp("R7", K_ACK, 0, 0);
    setupTok = 1; inTok = 1; step(); clearStrobes();
    checkResp("R7", K_ACK, 0, 0);

    // R2 set beats clear
    swNakSet = 1; swNakClr = 1; step(); clearStrobes();
    chk("R2", "set+clear", int'(nakSts), 1);

    // R3 NAK status blocks data on bulk
    epType = 2'd2; fifoCount = 11'd20; inTok = 1; step(); clearStrobes();
    checkResp("R3", K_NAK, 0, 0);

    // R2 token judged on old value when NAK set arrives in same cycle
    swNakClr = 1; step(); clearStrobes();
    fifoCount = 11'd5; maxPktSize = 11'd8; inTok = 1; swNakSet = 1; step(); clearStrobes();
    checkResp("R2", K_DATA, 5, 0);
    chk("R2", "nakSts after same-cycle set", int'(nakSts), 1);

    // R9 timeout leaves PID, stray ack leaves PID
    hsTimeout = 1; step(); clearStrobes();
    chk("R9", "pid after timeout", int'(dataPid), 0);
    hsAck = 1; step(); clearStrobes();
    chk("R9", "pid after stray ack", int'(dataPid), 0);

    // R9 ack toggles, then forced DATA0 beats toggle
    swNakClr = 1; step(); clearStrobes();
    inTok = 1; step(); clearStrobes();
    checkResp("R4", K_DATA, 5, 0);
    hsAck = 1; step(); clearStrobes();
    chk("R9", "pid after ack", int'(dataPid), 1);
    inTok = 1; step(); clearStrobes();
    checkResp("R4", K_DATA, 5, 1);
    hsAck = 1; swSetData0 = 1; step(); clearStrobes();
    chk("R9", "set DATA0 beats toggle", int'(dataPid), 0);

    // R9 isochronous data does not advance PID; R6 odd wins over even
    epType = 2'd1; swSetOdd = 1; swSetEven = 1; step(); clearStrobes();
    frameNum = 11'd7; inTok = 1; step(); clearStrobes();
    checkResp("R6", K_DATA, 5, 0);
    hsAck = 1; step(); clearStrobes();
    chk("R9", "pid after iso ack", int'(dataPid), 0);
    mPid = 0;

    // Near-exhaustive sweep (R3 R4 R5 R6 R9)
    for (int t = 0; t < 4; t++) begin
      for (int n = 0; n < 2; n++) begin
        for (int eo = 0; eo < 2; eo++) begin
          for (int fp = 0; fp < 2; fp++) begin
            for (int fi = 0; fi < 6; fi++) begin
              for (int mi = 0; mi < 2; mi++) begin
                int fifoV, mpsV, ek, el, ep;
                bit iso;
                fifoV = (fi == 0) ? 0 : (fi == 1) ? 1 : (fi == 2) ? 7 : (fi == 3) ? 8 : (fi == 4) ? 9 : 64;
                mpsV  = (mi == 0) ? 8 : 64;
                iso   = (t == 1);
                epType = 2'(t);
                if (n != 0) swNakSet = 1; else swNakClr = 1;
                if (eo != 0) swSetOdd = 1; else swSetEven = 1;
                step(); clearStrobes();
                frameNum = FRAME_W'((t * 96 + fi * 8 + mi * 2) * 2 + fp);
                fifoCount = CNT_W'(fifoV);
                maxPktSize = LEN_W'(mpsV);
                if (iso) ek = (n == 0 && fp == eo && fifoV != 0) ? K_DATA : K_ZLP;
                else     ek = (n == 0 && fifoV != 0) ? K_DATA : K_NAK;
                el = (ek == K_DATA) ? ((fifoV < mpsV) ? fifoV : mpsV) : 0;
                ep = (ek == K_DATA && !iso) ? mPid : 0;
                inTok = 1; step(); clearStrobes();
                checkResp(iso ? "R6" : (n != 0 ? "R3" : "R4"), ek, el, ep);
                hsAck = 1; step(); clearStrobes();
                if (ek == K_DATA && !iso) mPid ^= 1;
                chk("R9", "sweep pid", int'(dataPid), mPid);
              end
            end
          end
        end
      end
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule